// File: doc/BRIEF.md
# Tuner Synthesizer Serial Control Slave

This block is the serial control front end of a tuner frequency synthesizer. It is an I2C slave that works from the chip's system clock. It samples SCL and SDA through synchronizers and pulls SDA low through an open-drain enable. It answers one of four 7-bit addresses. The upper five address bits are a fixed parameter, and a two-pin strap supplies the lower two.

A write transfer sends a fixed sequence of data bytes. The first two bytes carry the 15-bit divider word, which takes effect as one update when the second byte arrives. The third byte holds the control bits: reference/comparison output enable and test mode. The fourth byte holds the levels and drive enables of four switching ports. A read transfer returns a status byte that reports the lock indication and the sensed level of the bidirectional port P3. In test mode, port P0 stops showing its latched level and shows the programmable divider output divided by two.

Top module: `tuner_i2c_ctrl`

## Requirements
- R1: The slave address is {5'b11000, addr_sel_i}. On a match the block acknowledges by holding SDA low for the whole ninth clock. On a mismatch it never pulls SDA low, and no register changes until the next START.
- R2: Bit 0 of the address byte selects the direction: 0 is a write (the slave takes bytes and acknowledges each one), 1 is a read (the slave sends status bytes).
- R3: Write data byte 1 bits [6:0] become divider bits [14:8]; bit 7 is ignored. Write data byte 2 becomes divider bits [7:0]. div_word_o changes only after byte 2, all at once, together with a one-cycle pulse on div_upd_o. After byte 1 alone, div_word_o keeps its old value.
- R4: After reset, port_oe_o is 0 (all ports high impedance), port_o is 0, div_word_o is 0, and refout_en_o, test_mode_o and sda_oe_o are 0.
- R5: Write data byte 3 is the control byte: bit 0 drives refout_en_o (0 disables the reference/comparison output) and bit 1 drives test_mode_o.
- R6: Write data byte 4 sets the ports. Bits [3:0] are the levels of P0..P3, and bits [7:4] are the drive enables of P0..P3 (1 drives, 0 is high impedance). Bytes after the fourth are acknowledged and have no effect.
- R7: In test mode, port_o[0] toggles on each rising edge of fpd_i, and port_oe_o[0] is 1 whatever the latched enable. The toggle flop is 0 after reset.
- R8: The status byte has bit 7 = lock_i, bit 0 = p3_pin_i when P3 is not driven and 0 when it is, and bits [6:1] = 0. After a master ACK the block sends another status byte. After a master NACK it releases SDA and waits for START.
- R9: Every START, including a repeated START, restarts the address phase and returns the write byte position to byte 1. A STOP ends the transfer. Transfers work when the SCL high and low times are each at least 8 system clocks, which covers standard and fast mode at usual system clock rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel_i | input | 2 | Strap that picks the low two address bits |
| lock_i | input | 1 | Loop lock indication reported in status |
| fpd_i | input | 1 | Programmable divider output |
| p3_pin_i | input | 1 | Sensed level of port P3 |
| port_o | output | 4 | Port levels P0..P3 |
| port_oe_o | output | 4 | Port drive enables P0..P3 |
| div_word_o | output | 15 | Committed divider word |
| div_upd_o | output | 1 | One-cycle pulse when div_word_o is updated |
| refout_en_o | output | 1 | Reference/comparison output enable |
| test_mode_o | output | 1 | Test mode: P0 shows the divider output divided by two |

## Verification
A wrong byte position or a lost staging byte shows up as a wrong divider, control or port value one system clock after the acknowledge falls. A commit that comes too early shows up as a div_update pulse between the two divider bytes. If the bit counter drifts, the acknowledge lands on the wrong clock, so the master sees a NACK or a shifted status byte within the same byte. A bad P0 multiplexer in test mode shows up within a few clocks of an fpd_i edge, because the P0 level stops following the pulse count.

// File: rtl/tuner_ctrl_pkg.sv
// Package: shared state type and write byte positions of the tuner control slave.
// Assumes: the byte positions follow the fixed write order of the block.
package tuner_ctrl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WDATA,
        ST_RDATA,
        ST_RACK
    } slv_state_t;

    localparam int BYTE_DIV_HI = 0;
    localparam int BYTE_DIV_LO = 1;
    localparam int BYTE_CTRL   = 2;
    localparam int BYTE_PORTS  = 3;
    localparam int NUM_WBYTES  = 4;
endpackage

// File: rtl/i2c_pin_sync.sv
// Module: synchronizer with edge detection for one asynchronous bus line.
// Assumes: the line is stable for well over STAGES+1 clocks between changes.
module i2c_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pin through the synchronizer and keep the last settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], d};
            prev  <= chain[STAGES-1];
        end
    end

    assign q    = chain[STAGES-1];
    assign rise = q & ~prev;
    assign fall = ~q & prev;
endmodule

// File: rtl/i2c_byte_slave.sv
// Module: bit and byte engine of the I2C slave. It matches the address,
// acknowledges bytes, hands write bytes out with their position, and sends
// status bytes on reads.
// Assumes: SCL and SDA come in synchronized, with edges as one-cycle strobes.
module i2c_byte_slave
    import tuner_ctrl_pkg::*;
#(
    parameter logic [4:0] ADDR_HI = 5'b11000,
    parameter int          IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda,
    input  logic             sda_rise,
    input  logic             sda_fall,
    input  logic [1:0]       addr_sel,
    input  logic [7:0]       status,
    output logic             sda_oe,
    output logic             wr_stb,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NUM_WBYTES);

    slv_state_t       state;
    logic [3:0]       cnt;
    logic [7:0]       sh;
    logic [7:0]       tx;
    logic             rd;
    logic [IDX_W-1:0] idx;
    logic             start_c;
    logic             stop_c;
    logic [6:0]       my_addr;

    assign start_c = scl & sda_fall;
    assign stop_c  = scl & sda_rise;
    assign my_addr = {ADDR_HI, addr_sel};

    // Main bus state machine: START/STOP first, then the per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '0;
            rd      <= 1'b0;
            idx     <= '0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_c) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                idx    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sh  <= {sh[6:0], sda};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (sh[7:1] == my_addr) begin
                                sda_oe <= 1'b1;
                                rd     <= sh[0];
                                state  <= ST_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rd) begin
                                tx     <= status;
                                sda_oe <= ~status[7];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            sh  <= {sh[6:0], sda};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            wr_stb  <= 1'b1;
                            wr_data <= sh;
                            wr_idx  <= idx;
                            idx     <= (idx == IDX_MAX) ? idx : idx + 1'b1;
                            sda_oe  <= 1'b1;
                            state   <= ST_ACK;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= ~tx[3'd7 - cnt[2:0]];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            if (sda) state <= ST_IDLE;
                        end else if (scl_fall) begin
                            tx     <= status;
                            sda_oe <= ~status[7];
                            cnt    <= '0;
                            state  <= ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: an idle slave (unaddressed or after a mismatch) never holds SDA.
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R8: a master NACK ends the read with SDA released.
    assert_nack_ends_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && scl_rise && sda && !start_c && !stop_c)
        |=> (state == ST_IDLE && !sda_oe));

    // R9: a START always restarts the address phase with SDA released.
    assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (state == ST_ADDR && !sda_oe && cnt == 4'd0));
endmodule

// File: rtl/tuner_reg_bank.sv
// Module: staging and committed registers of the synthesizer. It also holds
// the port latch with its test-mode override of P0.
// Assumes: wr_stb is a one-cycle strobe carrying the write byte position.
module tuner_reg_bank
    import tuner_ctrl_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int NPORTS = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              fpd_i,
    output logic [DIV_W-1:0]  div_word,
    output logic              div_upd,
    output logic              refout_en,
    output logic              test_mode,
    output logic [NPORTS-1:0] port_o,
    output logic [NPORTS-1:0] port_oe
);
    localparam int HI_W = DIV_W - 8;

    logic [HI_W-1:0]   hi_stage;
    logic [NPORTS-1:0] port_lvl;
    logic [NPORTS-1:0] port_drv;
    logic [2:0]        fpd_sync;
    logic              fpd_rise;
    logic              fpd_half;

    assign fpd_rise = fpd_sync[1] & ~fpd_sync[2];

    // Load the staged and committed registers from the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_stage  <= '0;
            div_word  <= '0;
            div_upd   <= 1'b0;
            refout_en <= 1'b0;
            test_mode <= 1'b0;
            port_lvl  <= '0;
            port_drv  <= '0;
        end else begin
            div_upd <= 1'b0;
            if (wr_stb) begin
                case (wr_idx)
                    IDX_W'(BYTE_DIV_HI): hi_stage <= wr_data[HI_W-1:0];
                    IDX_W'(BYTE_DIV_LO): begin
                        div_word <= {hi_stage, wr_data};
                        div_upd  <= 1'b1;
                    end
                    IDX_W'(BYTE_CTRL): begin
                        refout_en <= wr_data[0];
                        test_mode <= wr_data[1];
                    end
                    IDX_W'(BYTE_PORTS): begin
                        port_lvl <= wr_data[NPORTS-1:0];
                        port_drv <= wr_data[2*NPORTS-1:NPORTS];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Synchronize the divider output and halve it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fpd_sync <= '0;
            fpd_half <= 1'b0;
        end else begin
            fpd_sync <= {fpd_sync[1:0], fpd_i};
            if (fpd_rise) fpd_half <= ~fpd_half;
        end
    end

    // Port outputs: latched values, with P0 taken over in test mode.
    always_comb begin
        port_o  = port_lvl;
        port_oe = port_drv;
        if (test_mode) begin
            port_o[0]  = fpd_half;
            port_oe[0] = 1'b1;
        end
    end

    // R3: the divider word moves only together with its update pulse.
    assert_div_atomic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !div_upd |-> $stable(div_word));

    // R4: ports come out of reset high impedance.
    assert_ports_hiz_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (port_oe == '0));

    // R7: in test mode each divider edge toggles P0.
    assert_test_p0_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && fpd_rise && !wr_stb) |=> (port_o[0] != $past(port_o[0])));
endmodule

// File: rtl/tuner_i2c_ctrl.sv
// Module: top of the tuner synthesizer control slave. It connects the pin
// synchronizers, the byte engine and the register bank, and builds the status byte.
// Assumes: SCL high and low times of at least 8 clk cycles.
module tuner_i2c_ctrl
    import tuner_ctrl_pkg::*;
#(
    parameter logic [4:0] ADDR_HI = 5'b11000,
    parameter int          DIV_W   = 15,
    parameter int          NPORTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        addr_sel_i,
    input  logic              lock_i,
    input  logic              fpd_i,
    input  logic              p3_pin_i,
    output logic [NPORTS-1:0] port_o,
    output logic [NPORTS-1:0] port_oe_o,
    output logic [DIV_W-1:0]  div_word_o,
    output logic              div_upd_o,
    output logic              refout_en_o,
    output logic              test_mode_o
);
    localparam int IDX_W = $clog2(NUM_WBYTES + 1);

    logic             scl_q, scl_rise, scl_fall;
    logic             sda_q, sda_rise, sda_fall;
    logic             wr_stb;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic [7:0]       status;
    logic             p3_sense;

    i2c_pin_sync #(.STAGES(2), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_i),
        .q(scl_q), .rise(scl_rise), .fall(scl_fall));

    i2c_pin_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_i),
        .q(sda_q), .rise(sda_rise), .fall(sda_fall));

    // P3 reads back only when it is not being driven.
    assign p3_sense = port_oe_o[NPORTS-1] ? 1'b0 : p3_pin_i;
    assign status   = {lock_i, 6'd0, p3_sense};

    i2c_byte_slave #(.ADDR_HI(ADDR_HI), .IDX_W(IDX_W)) u_slave (
        .clk(clk), .rst_n(rst_n),
        .scl(scl_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda(sda_q), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .addr_sel(addr_sel_i), .status(status),
        .sda_oe(sda_oe_o), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data));

    tuner_reg_bank #(.DIV_W(DIV_W), .NPORTS(NPORTS), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data), .fpd_i(fpd_i),
        .div_word(div_word_o), .div_upd(div_upd_o),
        .refout_en(refout_en_o), .test_mode(test_mode_o),
        .port_o(port_o), .port_oe(port_oe_o));
endmodule

// File: tb/tb_tuner_i2c_ctrl.sv
// Bench: a bus master drives transfers. The driver queues expected divider
// updates, and a monitor pops and compares them on each update pulse.
module tb_tuner_i2c_ctrl;
    localparam int CLK_P = 10;
    localparam int H     = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [1:0]  addr_sel = 2'b10;
    logic        lock_i = 1'b0;
    logic        fpd_i = 1'b0;
    logic        p3_pin = 1'b0;
    logic [3:0]  port_o, port_oe;
    logic [14:0] div_word;
    logic        div_upd, refout_en, test_mode;
    wire         sda_bus = sda_m & ~sda_oe;

    int errors = 0;
    int checks = 0;
    logic [14:0] exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    tuner_i2c_ctrl dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .addr_sel_i(addr_sel), .lock_i(lock_i), .fpd_i(fpd_i), .p3_pin_i(p3_pin),
        .port_o(port_o), .port_oe_o(port_oe), .div_word_o(div_word),
        .div_upd_o(div_upd), .refout_en_o(refout_en), .test_mode_o(test_mode));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor (R3): each update pulse must match the oldest expected word.
    always @(negedge clk) begin
        if (rst_n && div_upd) begin
            if (exp_q.size() == 0) chk("R3 unexpected update", 32'(div_word), 32'h7fffffff);
            else chk("R3 divider commit", 32'(div_word), 32'(exp_q.pop_front()));
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; wclk(H); scl_m = 1'b1; wclk(H);
        sda_m = 1'b0; wclk(H); scl_m = 1'b0; wclk(2);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; wclk(H); scl_m = 1'b1; wclk(H); sda_m = 1'b1; wclk(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wclk(H); scl_m = 1'b1; wclk(H); scl_m = 1'b0; wclk(2);
    endtask

    task automatic recv_bit(output logic v);
        sda_m = 1'b1; wclk(H); scl_m = 1'b1; wclk(H/2); v = sda_bus;
        wclk(H/2); scl_m = 1'b0; wclk(2);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(v);
        ack = ~v;
    endtask

    task automatic rd_byte(input logic m_ack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(v);
            b[i] = v;
        end
        send_bit(~m_ack);
    endtask

    // Full write transfer to the matched address, with every acknowledge checked.
    task automatic write_xfer(input int n, input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] b4);
        logic ack;
        logic [7:0] bs [5];
        bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3; bs[4] = b4;
        i2c_start;
        wr_byte({5'b11000, addr_sel, 1'b0}, ack);
        chk("R1 R2 write address ack", 32'(ack), 32'd1);
        for (int i = 0; i < n; i++) begin
            wr_byte(bs[i], ack);
            chk("R2 data byte ack", 32'(ack), 32'd1);
        end
        i2c_stop;
    endtask

    initial begin
        logic ack;
        logic [7:0] rb;
        wclk(5);
        // R4: reset state
        chk("R4 port_oe", 32'(port_oe), 32'h0);
        chk("R4 port_o", 32'(port_o), 32'h0);
        chk("R4 div_word", 32'(div_word), 32'h0);
        chk("R4 refout/test/sda", 32'({refout_en, test_mode, sda_oe}), 32'h0);
        rst_n = 1'b1;
        wclk(5);

        // R3: no commit after the first divider byte, one commit after the second
        exp_q.push_back(15'h1234);
        i2c_start;
        wr_byte(8'hC4, ack);
        chk("R1 address 0x62 ack", 32'(ack), 32'd1);
        wr_byte(8'h12, ack);
        wclk(3);
        chk("R3 held after first byte", 32'(div_word), 32'h0);
        wr_byte(8'h34, ack);
        i2c_stop;
        chk("R3 divider word", 32'(div_word), 32'h1234);

        // R1: mismatched address is not acknowledged and changes nothing
        i2c_start;
        wr_byte(8'hC0, ack);
        chk("R1 mismatch nack", 32'(ack), 32'd0);
        wr_byte(8'h55, ack);
        chk("R1 ignored after mismatch", 32'(ack), 32'd0);
        i2c_stop;
        chk("R1 divider unchanged", 32'(div_word), 32'h1234);

        // R3 R5 R6: full write plus an extra byte that must do nothing
        exp_q.push_back(15'h7FFF);
        write_xfer(5, 8'hFF, 8'hFF, 8'h01, 8'h5A, 8'hFF);
        chk("R3 bit 7 of high byte ignored", 32'(div_word), 32'h7FFF);
        chk("R5 refout enable", 32'(refout_en), 32'd1);
        chk("R5 test mode off", 32'(test_mode), 32'd0);
        chk("R6 port levels", 32'(port_o), 32'hA);
        chk("R6 port enables, extra byte ignored", 32'(port_oe), 32'h5);

        // R8: status read with P3 undriven, master ACK then NACK
        lock_i = 1'b1; p3_pin = 1'b1;
        i2c_start;
        wr_byte(8'hC5, ack);
        chk("R2 read address ack", 32'(ack), 32'd1);
        rd_byte(1'b1, rb);
        chk("R8 status lock and P3", 32'(rb), 32'h81);
        rd_byte(1'b0, rb);
        chk("R8 status after master ack", 32'(rb), 32'h81);
        wclk(4);
        chk("R8 SDA released after NACK", 32'(sda_oe), 32'd0);
        i2c_stop;

        // R6 R8: P3 driven, so its pin level is ignored in status
        exp_q.push_back(15'h0005);
        write_xfer(4, 8'h00, 8'h05, 8'h00, 8'hF8, 8'h00);
        chk("R6 all ports driven", 32'(port_oe), 32'hF);
        chk("R6 level pattern", 32'(port_o), 32'h8);
        chk("R5 refout disabled", 32'(refout_en), 32'd0);
        lock_i = 1'b0;
        i2c_start;
        wr_byte(8'hC5, ack);
        rd_byte(1'b0, rb);
        i2c_stop;
        chk("R8 P3 input ignored when driven", 32'(rb), 32'h00);

        // R7: test mode puts the halved divider output on P0
        exp_q.push_back(15'h0005);
        write_xfer(4, 8'h00, 8'h05, 8'h02, 8'h00, 8'h00);
        chk("R5 test mode on", 32'(test_mode), 32'd1);
        chk("R7 P0 forced driven", 32'(port_oe), 32'h1);
        chk("R7 P0 starts low", 32'(port_o[0]), 32'd0);
        for (int k = 1; k <= 3; k++) begin
            fpd_i = 1'b1; wclk(4); fpd_i = 1'b0; wclk(4);
            chk("R7 P0 toggles per divider edge", 32'(port_o[0]), 32'(k % 2));
        end

        // R9: repeated START returns the write position to byte 1
        exp_q.push_back(15'h0009);
        i2c_start;
        wr_byte(8'hC4, ack);
        wr_byte(8'h03, ack);
        i2c_start;
        wr_byte(8'hC4, ack);
        chk("R9 repeated start address ack", 32'(ack), 32'd1);
        wr_byte(8'h00, ack);
        wr_byte(8'h09, ack);
        i2c_stop;
        chk("R9 divider after repeated start", 32'(div_word), 32'h0009);

        // R9: STOP after one byte, next transfer starts at byte 1 again
        exp_q.push_back(15'h000A);
        i2c_start;
        wr_byte(8'hC4, ack);
        wr_byte(8'h04, ack);
        i2c_stop;
        chk("R9 no commit after lone byte", 32'(div_word), 32'h0009);
        write_xfer(2, 8'h00, 8'h0A, 8'h00, 8'h00, 8'h00);
        chk("R9 divider after stop", 32'(div_word), 32'h000A);

        // R1: a different strap value selects a different address
        addr_sel = 2'b01;
        i2c_start;
        wr_byte(8'hC4, ack);
        chk("R1 old address rejected", 32'(ack), 32'd0);
        i2c_stop;
        i2c_start;
        wr_byte(8'hC2, ack);
        chk("R1 strap address 0x61 ack", 32'(ack), 32'd1);
        i2c_stop;

        wclk(5);
        chk("R3 all expected updates seen", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule